// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Selectable Pin Level

This block merges two sets of sticky interrupt status flags into one interrupt pin. The first set is 8 bits wide and each of its bits has its own enable. The second set is 16 bits wide and one group-wide enable gates all of its bits. A one-cycle event pulse sets a status bit. The bit stays set until the read strobe for its group clears the whole group. The flags latch whether or not they are enabled, so software can still poll an event that was masked.

When at least one enabled flag is set, the block drives the pin. The asserted level is high or low, as set by a polarity input. When no enabled flag is set, the output enable drops so the pad floats. The drive value and the output enable both come from flops, so the pin cannot glitch while the status, enables or polarity settle. The register map around the block and the pad itself sit outside it.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is low and in the first cycle after it, both status words read zero and `irq_oe` is 0.
- R2: When bit i of an event input is 1 at a rising clock edge, status bit i of that group reads 1 after that edge. It stays 1 until a clear for its group, whatever the enables are.
- R3: A 1 on `clr_a` or `clr_b` at a clock edge sets every status bit of that group to 0. The other group's status is left unchanged.
- R4: If an event bit and its group's clear are both 1 at the same edge, that status bit reads 1 after the edge.
- R5: A set bit i of the 8-bit group counts as pending only while `en_a[i]` is 1.
- R6: A set bit of the 16-bit group counts as pending only while `en_b` is 1.
- R7: `irq_oe` is 1 exactly when at least one pending bit existed at the previous clock edge. Otherwise it is 0 and the pin is released.
- R8: While `irq_oe` is 1, `irq_drv` equals the value that `pol_high` had at the previous edge. 1 means the pin is asserted high and 0 means it is asserted low.
- R9: `irq_oe` and `irq_drv` change only at a clock edge, one edge after the status, enables or polarity change. An event is therefore seen on the pin two edges after its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_a | input | 8 | Event pulses, 8-bit group |
| evt_b | input | 16 | Event pulses, 16-bit group |
| en_a | input | 8 | Per-bit enables, 8-bit group |
| en_b | input | 1 | Group enable, 16-bit group |
| pol_high | input | 1 | Asserted pin level: 1 high, 0 low |
| clr_a | input | 1 | Clear-on-read strobe, 8-bit group |
| clr_b | input | 1 | Clear-on-read strobe, 16-bit group |
| stat_a | output | 8 | Status flags, 8-bit group |
| stat_b | output | 16 | Status flags, 16-bit group |
| irq_drv | output | 1 | Pin drive value |
| irq_oe | output | 1 | Pin output enable, 0 releases the pin |

## Verification
The sequence first sets a flag while its enable is off, then turns the enable on. This shows that latching and masking are separate: the status changes but the pin does not. The same pending state is then run under both polarities, which shows the drive level follows `pol_high` and not the pending state. Some patterns clear one group while the other is still pending, or raise an event in the same cycle as its clear. These show the groups stay independent and that a new event wins over a clear. Directed steps then count edges from an event to the pin and from an enable drop to release, which pins down the single register stage.

// File: rtl/irq_agg_pkg.sv
// Package: shared widths and pin level type for the interrupt aggregator.
// Assumes: both groups are no wider than 32 bits.
package irq_agg_pkg;
    localparam int GRP_A_W = 8;
    localparam int GRP_B_W = 16;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } irq_level_e;
endpackage

// File: rtl/irq_status_group.sv
// Module: one group of sticky status flags plus its masked pending flag.
// Events set flags. A group clear resets them unless an event hits the same cycle.
// EN_W == WIDTH gives per-bit enables. EN_W == 1 gives one enable for the whole group.
// Assumes: clr_i is a single-cycle strobe issued by the register read logic.
module irq_status_group #(
    parameter int WIDTH = 8,
    parameter int EN_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic [EN_W-1:0]  en_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] stat_o,
    output logic             hit_o
);
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] stat_q;

    // Enable expansion: the parameter picks the per-bit or group-wide variant.
    generate
        if (EN_W == WIDTH) begin : g_per_bit
            assign mask = en_i;
        end else begin : g_group
            assign mask = {WIDTH{en_i[0]}};
        end
    endgenerate

    // Status flags: set on event, cleared by strobe, event takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (clr_i) begin
            stat_q <= evt_i;
        end else begin
            stat_q <= stat_q | evt_i;
        end
    end

    // Pending flag: any flag whose enable is on.
    always_comb begin
        hit_o = |(stat_q & mask);
    end

    assign stat_o = stat_q;

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i))); // R2
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R2
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (evt_i == '0)) |=> (stat_o == '0)); // R3
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (evt_i != '0)) |=> (stat_o == $past(evt_i))); // R4
endmodule

// File: rtl/irq_pin_drive.sv
// Module: registered pin driver. It drives the chosen active level while an
// interrupt is pending and releases the pin (oe low) otherwise.
// Assumes: pend_i and pol_i come from logic in the same clock domain.
module irq_pin_drive
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend_i,
    input  irq_level_e pol_i,
    output logic       drv_o,
    output logic       oe_o
);
    // Pin registers: output enable follows pending, drive is the asserted or idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o  <= 1'b0;
            drv_o <= 1'b0;
        end else begin
            oe_o  <= pend_i;
            drv_o <= pend_i ? logic'(pol_i) : ~logic'(pol_i);
        end
    end

    AST_OE_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i |=> oe_o); // R7
    AST_OE_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_i |=> !oe_o); // R7
    AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i |=> (drv_o == $past(logic'(pol_i)))); // R8
    AST_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pend_i) && $stable(pol_i)) |=> ($stable(oe_o) && $stable(drv_o))); // R9
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator. It holds an 8-bit group with per-bit
// enables and a 16-bit group with one enable, and feeds one tri-state pin.
// Assumes: synchronous active-low reset, with all inputs synchronous to clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int A_W = GRP_A_W,
    parameter int B_W = GRP_B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] evt_a,
    input  logic [B_W-1:0] evt_b,
    input  logic [A_W-1:0] en_a,
    input  logic           en_b,
    input  logic           pol_high,
    input  logic           clr_a,
    input  logic           clr_b,
    output logic [A_W-1:0] stat_a,
    output logic [B_W-1:0] stat_b,
    output logic           irq_drv,
    output logic           irq_oe
);
    logic       hit_a;
    logic       hit_b;
    logic       pend;
    irq_level_e pol;

    irq_status_group #(.WIDTH(A_W), .EN_W(A_W)) u_grp_a (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_a), .en_i(en_a),
        .clr_i(clr_a), .stat_o(stat_a), .hit_o(hit_a)
    );

    irq_status_group #(.WIDTH(B_W), .EN_W(1)) u_grp_b (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_b), .en_i(en_b),
        .clr_i(clr_b), .stat_o(stat_b), .hit_o(hit_b)
    );

    // Pending merge and polarity decode for the pin driver.
    always_comb begin
        pend = hit_a | hit_b;
        pol  = pol_high ? LVL_HIGH : LVL_LOW;
    end

    irq_pin_drive u_pin (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .pol_i(pol),
        .drv_o(irq_drv), .oe_o(irq_oe)
    );

    AST_MASKED_A_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat_a & en_a) == '0) && !(en_b && (stat_b != '0))) |=> !irq_oe); // R5
    AST_MASKED_B_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_b && ((stat_a & en_a) == '0)) |=> !irq_oe); // R6
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_a = '0;
    logic [15:0] evt_b = '0;
    logic [7:0]  en_a = '0;
    logic        en_b = 1'b0;
    logic        pol_high = 1'b1;
    logic        clr_a = 1'b0;
    logic        clr_b = 1'b0;
    logic [7:0]  stat_a;
    logic [15:0] stat_b;
    logic        irq_drv;
    logic        irq_oe;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b), .en_a(en_a),
        .en_b(en_b), .pol_high(pol_high), .clr_a(clr_a), .clr_b(clr_b),
        .stat_a(stat_a), .stat_b(stat_b), .irq_drv(irq_drv), .irq_oe(irq_oe)
    );

    // Vector: req(4) evt_a(8) evt_b(16) en_a(8) en_b pol clr_a clr_b | stat_a(8) stat_b(16) oe drv
    localparam int NV = 10;
    localparam logic [65:0] VEC [NV] = '{
        {4'd2, 8'h01, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0000, 1'b0, 1'b0}, // R2 R5 masked latch
        {4'd5, 8'h00, 16'h0000, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0000, 1'b1, 1'b1}, // R5 enable, R8 high
        {4'd8, 8'h00, 16'h0000, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 16'h0000, 1'b1, 1'b0}, // R8 low
        {4'd3, 8'h00, 16'h0000, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R3 clear, R7 release
        {4'd6, 8'h00, 16'h8000, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h8000, 1'b0, 1'b0}, // R6 masked
        {4'd6, 8'h00, 16'h0000, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'h8000, 1'b1, 1'b1}, // R6 enabled
        {4'd3, 8'h80, 16'h0000, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 16'h0000, 1'b1, 1'b1}, // R3 other group kept
        {4'd4, 8'h80, 16'h0000, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 16'h0000, 1'b1, 1'b1}, // R4 event vs clear
        {4'd4, 8'h02, 16'h0000, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 8'h02, 16'h0000, 1'b0, 1'b0}, // R4 R5 new bit masked
        {4'd4, 8'h00, 16'h0001, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 16'h0001, 1'b1, 1'b0}  // R4 group b, R8 low
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stat_a", 32'(stat_a), 32'h0);
        check("R1 stat_b", 32'(stat_b), 32'h0);
        check("R1 oe", 32'(irq_oe), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [65:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[65:62], i);
            evt_a = v[61:54]; evt_b = v[53:38]; en_a = v[37:30]; en_b = v[29];
            pol_high = v[28]; clr_a = v[27]; clr_b = v[26];
            @(negedge clk);
            evt_a = '0; evt_b = '0; clr_a = 1'b0; clr_b = 1'b0;
            @(negedge clk);
            check({tag, " stat_a"}, 32'(stat_a), 32'(v[25:18]));
            check({tag, " stat_b"}, 32'(stat_b), 32'(v[17:2]));
            check({tag, " oe"}, 32'(irq_oe), 32'(v[1]));
            if (v[1]) check({tag, " drv"}, 32'(irq_drv), 32'(v[0]));
        end

        // R9 timing: event reaches status after one edge, pin after two
        clr_a = 1'b1; clr_b = 1'b1; en_a = 8'hFF; en_b = 1'b0; pol_high = 1'b1;
        @(negedge clk);
        clr_a = 1'b0; clr_b = 1'b0;
        @(negedge clk);
        check("R9 idle oe", 32'(irq_oe), 32'h0);
        evt_a = 8'h04;
        @(negedge clk);
        evt_a = '0;
        check("R9 stat set", 32'(stat_a), 32'h04);
        check("R9 oe not yet", 32'(irq_oe), 32'h0);
        @(negedge clk);
        check("R9 oe after two edges", 32'(irq_oe), 32'h1);
        check("R8 drv high", 32'(irq_drv), 32'h1);
        // R9 polarity change shows one edge later
        pol_high = 1'b0;
        @(negedge clk);
        check("R9 drv follows pol", 32'(irq_drv), 32'h0);
        // R5 R9 enable drop releases pin one edge later, flag kept
        en_a = 8'hFB;
        @(negedge clk);
        check("R9 oe released", 32'(irq_oe), 32'h0);
        check("R2 flag kept while masked", 32'(stat_a), 32'h04);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stat_a after reset", 32'(stat_a), 32'h0);
        check("R1 oe after reset", 32'(irq_oe), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule